// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block produces the bus control strobes for the interrupt acknowledge machine cycle of an 8-bit processor whose bus has active-low M1, IORQ, MREQ and RFSH signals. The core raises `instrEnd` for one clock on the last clock of each instruction. If the level-sensitive request `intReqN` is low on that edge, the request is accepted. One full clock later the sequencer starts the acknowledge cycle by pulling M1 low.

IORQ is held back until the falling edge in the middle of the third clock of the cycle. The gap between M1 and IORQ gives an external priority daisy chain time to settle before the interrupting device drives its vector. The byte on the data bus is captured on the rising edge that ends the M1 phase. It is kept as the vector for the core. Two refresh clocks follow, during which the refresh address is driven and the 7-bit refresh counter advances. The cycle is one clock longer in modes 1 and 2 than in mode 0. `done` marks its final clock.

Top module: `int_ack_seq`

## Requirements
- R1: A request is accepted only on a rising edge where `instrEnd` is 1 and `intReqN` is 0. M1 falls on the rising edge one clock later. In half-clock steps counted from the accepting edge, that is step 2.
- R2: Steps below count half-clocks from the M1 falling edge (step 0). `m1N` stays low from step 0 to step 8 and goes high at step 8.
- R3: `iorqN` falls at step 5, the falling edge in the third clock, and rises at step 8 (1.5 clocks low). It is never low while `m1N` is high.
- R4: `vector` takes the value on `dataIn` at the rising edge of step 8. It holds that value until the next acknowledge.
- R5: `rfshN` and `mreqN` are both low from step 8 to step 12 and high at all other times. While they are low, `refreshAddr` equals `{iVal, 1'b0, R}`, where R is the 7-bit refresh counter. `refreshAddr` is 0 otherwise.
- R6: R is 0 after reset. It increases by one, modulo 128, after each acknowledge.
- R7: `intMode` is latched at acceptance. Code 0 selects mode 0, code 1 selects mode 1, and codes 2 and 3 select mode 2. In mode 0 the cycle lasts 6 clocks and `done` is high from step 10 to step 12. In modes 1 and 2 it lasts 7 clocks, `done` is high from step 12 to step 14, and all strobes stay high during the extra clock.
- R8: `instrEnd` pulses while `intReqN` is high are ignored. A low `intReqN` without `instrEnd` is ignored. An `instrEnd` pulse that arrives during an acknowledge is ignored. None of these produces an M1 low.
- R9: After reset, `m1N`, `iorqN`, `mreqN` and `rfshN` are 1, and `done` and `vector` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Synchronous active-low reset |
| instrEnd | input | 1 | Last clock of the current instruction |
| intReqN | input | 1 | Level interrupt request, active low |
| intMode | input | 2 | Interrupt mode code |
| dataIn | input | 8 | Data bus input |
| iVal | input | 8 | Interrupt page register, upper refresh address byte |
| m1N | output | 1 | M1 strobe, active low |
| iorqN | output | 1 | IORQ strobe, active low |
| mreqN | output | 1 | MREQ strobe, active low |
| rfshN | output | 1 | Refresh strobe, active low |
| refreshAddr | output | 16 | Refresh address during the refresh phase |
| vector | output | 8 | Latched vector byte |
| done | output | 1 | High on the final clock of the acknowledge cycle |

## Verification
The strobes are sampled after every clock edge, both rising and falling. The bench records the half-step at which each strobe falls and rises and compares it with a table for each mode code. This separates a late or early IORQ from a wrong cycle length. The data bus carries the right byte only between the edges around the capture point, so a capture one clock early or late shows up as a wrong vector. Requests without an instruction end, instruction ends without a request, and an instruction end during an acknowledge separate the accept condition from the state guard. A run of more than 128 acknowledges checks that the refresh counter wraps.

// File: rtl/ack_pkg.sv
package ack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCEPT = 2'd1,
    ST_ACK    = 2'd2
  } ackState_t;

  typedef struct packed {
    logic captureVec;
    logic bumpR;
    logic rfshPhase;
  } dpCtl_t;
endpackage

// File: rtl/ack_ctrl.sv
module ack_ctrl
  import ack_pkg::*;
#(
  parameter int TICK_W = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   instrEnd,
  input  logic   intReqN,
  input  logic [1:0] intMode,
  output logic   m1N,
  output logic   iorqN,
  output logic   mreqN,
  output logic   rfshN,
  output logic   done,
  output dpCtl_t dpCtl
);
  localparam logic [TICK_W-1:0] IORQ_T    = TICK_W'(3);
  localparam logic [TICK_W-1:0] M1_LAST_T = TICK_W'(4);
  localparam logic [TICK_W-1:0] RF_LAST_T = TICK_W'(6);
  localparam logic [TICK_W-1:0] SHORT_T   = TICK_W'(6);
  localparam logic [TICK_W-1:0] LONG_T    = TICK_W'(7);

  ackState_t state;
  logic [TICK_W-1:0] tick;
  logic longCycle;
  logic iorqArm;
  logic [TICK_W-1:0] lastT;
  logic inAck, m1Phase, iorqWin, rfshPhase;

  assign lastT = longCycle ? LONG_T : SHORT_T;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      tick      <= '0;
      longCycle <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (instrEnd && !intReqN) begin
          state     <= ST_ACCEPT;
          longCycle <= (intMode != 2'd0);
        end
        ST_ACCEPT: begin
          state <= ST_ACK;
          tick  <= TICK_W'(1);
        end
        ST_ACK: if (tick == lastT) begin
          state <= ST_IDLE;
          tick  <= '0;
        end else begin
          tick <= tick + TICK_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    inAck     = (state == ST_ACK);
    m1Phase   = inAck && (tick <= M1_LAST_T);
    iorqWin   = inAck && (tick >= IORQ_T) && (tick <= M1_LAST_T);
    rfshPhase = inAck && (tick > M1_LAST_T) && (tick <= RF_LAST_T);
  end

  // IORQ is launched on the falling edge inside its window
  always_ff @(negedge clk) begin
    if (!rstN) iorqArm <= 1'b0;
    else       iorqArm <= iorqWin;
  end

  assign m1N   = ~m1Phase;
  assign iorqN = ~(iorqWin && iorqArm);
  assign rfshN = ~rfshPhase;
  assign mreqN = ~rfshPhase;
  assign done  = inAck && (tick == lastT);
  assign dpCtl.captureVec = inAck && (tick == M1_LAST_T);
  assign dpCtl.bumpR      = inAck && (tick == RF_LAST_T);
  assign dpCtl.rfshPhase  = rfshPhase;

  a_r3_iorq_inside_m1: assert property (@(posedge clk) disable iff (!rstN)
    !iorqN |-> !m1N);
  a_r5_rfsh_after_m1: assert property (@(posedge clk) disable iff (!rstN)
    !rfshN |-> m1N);
  a_r2_m1_held: assert property (@(posedge clk) disable iff (!rstN)
    $fell(m1N) |=> !m1N);
  a_r7_done_follows_rfsh: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(!rfshN));
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(instrEnd && !intReqN)) |=> m1N);
endmodule

// File: rtl/ack_datapath.sv
module ack_datapath
  import ack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int R_W    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] iVal,
  output logic [DATA_W-1:0] vector,
  output logic [2*DATA_W-1:0] refreshAddr
);
  localparam int PAD_W = DATA_W - R_W;

  logic [R_W-1:0] rReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vector <= '0;
      rReg   <= '0;
    end else begin
      if (dpCtl.captureVec) vector <= dataIn;
      if (dpCtl.bumpR)      rReg   <= rReg + R_W'(1);
    end
  end

  assign refreshAddr = dpCtl.rfshPhase ? {iVal, {PAD_W{1'b0}}, rReg} : '0;

  a_r4_vector_held: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.captureVec |=> $stable(vector));
  a_r6_r_moves_once: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.rfshPhase && !dpCtl.bumpR |=> $stable(rReg));
endmodule

// File: rtl/int_ack_seq.sv
module int_ack_seq
  import ack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrEnd,
  input  logic       intReqN,
  input  logic [1:0] intMode,
  input  logic [7:0] dataIn,
  input  logic [7:0] iVal,
  output logic       m1N,
  output logic       iorqN,
  output logic       mreqN,
  output logic       rfshN,
  output logic [15:0] refreshAddr,
  output logic [7:0] vector,
  output logic       done
);
  dpCtl_t dpCtl;

  ack_ctrl #(.TICK_W(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .instrEnd(instrEnd), .intReqN(intReqN),
    .intMode(intMode), .m1N(m1N), .iorqN(iorqN), .mreqN(mreqN),
    .rfshN(rfshN), .done(done), .dpCtl(dpCtl)
  );

  ack_datapath #(.DATA_W(8), .R_W(7)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .dataIn(dataIn), .iVal(iVal),
    .vector(vector), .refreshAddr(refreshAddr)
  );
endmodule

// File: tb/sim_int_ack_seq.sv
`timescale 1ns/100ps
module sim_int_ack_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrEnd = 1'b0;
  logic intReqN = 1'b1;
  logic [1:0] intMode = 2'd0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] iVal = 8'h3C;
  logic m1N, iorqN, mreqN, rfshN, done;
  logic [15:0] refreshAddr;
  logic [7:0] vector;

  int checks = 0;
  int fails = 0;
  int ackCount = 0;

  always #2 clk = ~clk;

  int_ack_seq u0 (
    .clk(clk), .rstN(rstN), .instrEnd(instrEnd), .intReqN(intReqN),
    .intMode(intMode), .dataIn(dataIn), .iVal(iVal), .m1N(m1N),
    .iorqN(iorqN), .mreqN(mreqN), .rfshN(rfshN), .refreshAddr(refreshAddr),
    .vector(vector), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Full acknowledge; edge positions recorded as half-steps from M1 fall
  task automatic runAck(input logic [1:0] mode, input logic [7:0] vec, input bit quiet);
    int m1F = -99, m1R = -99, ioF = -99, ioR = -99, rfF = -99, rfR = -99;
    int dnR = -99, dnF = -99, m1Falls = 0, badMreq = 0, badAddr = 0;
    logic pm1 = 1'b1, pio = 1'b1, prf = 1'b1, pdn = 1'b0;
    logic [15:0] expAddr;
    bit longM;
    longM = (mode != 2'd0);
    expAddr = {iVal, 1'b0, 7'(ackCount)};
    @(negedge clk);
    intMode = mode; instrEnd = 1'b1; intReqN = 1'b0; dataIn = ~vec;
    for (int k = 0; k < 32; k++) begin
      int s;
      @(clk); #0.5;
      s = k - 2;
      if (pm1 && !m1N) begin m1F = s; m1Falls++; end
      if (!pm1 && m1N) m1R = s;
      if (pio && !iorqN) ioF = s;
      if (!pio && iorqN) ioR = s;
      if (prf && !rfshN) rfF = s;
      if (!prf && rfshN) rfR = s;
      if (!pdn && done) dnR = s;
      if (pdn && !done) dnF = s;
      if (mreqN !== rfshN) badMreq++;
      if (!rfshN && refreshAddr !== expAddr) badAddr++;
      if (rfshN && refreshAddr !== 16'h0) badAddr++;
      pm1 = m1N; pio = iorqN; prf = rfshN; pdn = done;
      if (k == 0) begin instrEnd = 1'b0; intReqN = 1'b1; end
      if (k == 8) dataIn = vec;
      if (k == 11) dataIn = ~vec;
    end
    ackCount++;
    if (quiet) begin
      check(badAddr == 0, "R6 wrap refresh address", badAddr, 0);
      return;
    end
    check(m1F == 0 && m1Falls == 1, "R1 M1 one clock after accept", m1F, 0);
    check(m1R == 8, "R2 M1 rise step", m1R, 8);
    check(ioF == 5, "R3 IORQ fall step", ioF, 5);
    check(ioR == 8, "R3 IORQ rise step", ioR, 8);
    check(vector == vec, "R4 vector captured", vector, vec);
    check(rfF == 8 && rfR == 12, "R5 RFSH window", rfF * 100 + rfR, 812);
    check(badMreq == 0, "R5 MREQ tracks RFSH", badMreq, 0);
    check(badAddr == 0, "R5 R6 refresh address", badAddr, 0);
    check(dnR == (longM ? 12 : 10), "R7 done start", dnR, longM ? 12 : 10);
    check(dnF == (longM ? 14 : 12), "R7 done end", dnF, longM ? 14 : 12);
  endtask

  // Stimulus that must not start an acknowledge
  task automatic noAck(input logic ie, input logic req, input string tag);
    int lows = 0;
    logic [7:0] held;
    held = vector;
    @(negedge clk);
    instrEnd = ie; intReqN = req; dataIn = 8'hEE;
    for (int k = 0; k < 24; k++) begin
      @(clk); #0.5;
      if (!m1N || !iorqN || !rfshN) lows++;
      if (k == 1) instrEnd = 1'b0;
    end
    intReqN = 1'b1;
    check(lows == 0, tag, lows, 0);
    check(vector == held, "R4 vector held while idle", vector, held);
  endtask

  // instrEnd pulse inside an acknowledge, request kept low afterwards
  task automatic pulseDuringAck();
    int m1Falls = 0;
    logic pm1 = 1'b1;
    @(negedge clk);
    intMode = 2'd1; instrEnd = 1'b1; intReqN = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(clk); #0.5;
      if (pm1 && !m1N) m1Falls++;
      pm1 = m1N;
      if (k == 0 || k == 11) instrEnd = 1'b0;
      if (k == 9) instrEnd = 1'b1;
    end
    intReqN = 1'b1;
    ackCount++;
    check(m1Falls == 1, "R8 instrEnd during ack ignored", m1Falls, 1);
  endtask

  task automatic resetCheck();
    #0.5;
    check(m1N && iorqN && mreqN && rfshN, "R9 strobes idle in reset",
          {m1N, iorqN, mreqN, rfshN}, 15);
    check(!done && vector == 8'h00, "R9 done and vector clear", vector, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    resetCheck();
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(posedge clk);
    runAck(2'd0, 8'hA5, 1'b0);
    runAck(2'd1, 8'h5A, 1'b0);
    runAck(2'd2, 8'hC3, 1'b0);
    runAck(2'd3, 8'h18, 1'b0);
    noAck(1'b1, 1'b1, "R8 instrEnd without request ignored");
    noAck(1'b0, 1'b0, "R8 request without instrEnd ignored");
    pulseDuringAck();
    noAck(1'b0, 1'b1, "R8 no late ack after pulse");
    // R6: run past 128 acknowledges so the counter wraps
    while (ackCount < 131) runAck(2'(ackCount % 3), 8'(ackCount), 1'b1);
    runAck(2'd0, 8'h77, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule